// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees a two-wire serial bus that is stuck because a slave keeps SDA low. The usual cause is a master reset in the middle of a transfer. On a start strobe, the block first watches the bus for one SCL period. If SDA is high at the end of that window, the bus is free and the block reports success at once, without clocking the bus.

If SDA is low, the block runs recovery attempts. Each attempt leaves the lines released for a cycle and arms for one more. It then clocks nine SCL pulses with SDA released, so the slave can shift out the rest of its byte and its acknowledge slot. After the burst the block returns to the released state. A computed idle gap separates one attempt from the next.

SDA is sampled at the end of every SCL high phase. As soon as it reads high, the block sends a STOP condition and reports success. When every attempt is used up and SDA is still low, the block reports failure. Both lines are open-drain: the block only pulls them low or lets them go. Every timed phase starts counting from the synchronised level of SCL, so a slave that stretches the clock is respected.

Top module: `i2c_bus_clear`

## Requirements
- R1: While reset is active and after its release, both line-pull enables are low and busy, done and fail are low.
- R2: A start strobe seen while busy is low raises busy in the next cycle. Busy stays high up to and including the single done cycle and is low in the cycle after it. A start strobe seen while busy is high, including in the done cycle, has no effect.
- R3: The idle check lasts 2*half_div system clocks. If SDA reads high at its end, done is given with fail low and no SCL edge is produced.
- R4: The block never drives a line high; its outputs are pull-low enables only. Both enables are low whenever busy is low.
- R5: Every SCL high phase produced by the block lasts at least half_div clocks, counted from the moment SCL reads high. Every SCL low phase lasts at least half_div clocks. A slave that holds SCL low lengthens the low phase.
- R6: One attempt is exactly nine SCL pulses with SDA released, and at most 9 attempts are made.
- R7: If SDA reads high at the end of a high phase, pulses stop and a STOP is sent. The STOP order is: SCL low, then SDA low, then SCL released, then SDA released. Done follows with fail low. If the slave lets go of SDA after its k-th SCL falling edge (k at most 81), exactly k pulses plus the STOP's SCL rise are seen.
- R8: Between attempts, SCL stays released for at least 2*B*P system clocks. Here P is us_pre (the value 0 is treated as 1) and B = max(2, floor(2*half_div/P) + 1).
- R9: If SDA is still low after the 81st pulse, done is given with fail high, no STOP is sent, and exactly 81 pulses are seen.
- R10: Done is a one-cycle pulse. Fail keeps its value from done until the next accepted start strobe, which clears it.
- R11: SDA is never pulled low while SCL is released, so the block never produces a START condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start-recovery strobe |
| half_div_i | input | 12 | SCL half period in system clocks |
| us_pre_i | input | 8 | System clocks per microsecond (0 acts as 1) |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when high |
| sda_oe_o | output | 1 | Pull SDA low when high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| fail_o | output | 1 | Bus still held after the last attempt; valid from done |

## Verification
Two events can land in the same cycle: a new start strobe and the done pulse that ends the current sequence. The bench provokes this by raising start at the very negative edge where it first sees done. The strobe is then sampled while the block is still busy. It is judged ignored only if busy stays low for the following cycles and no further SCL edge appears. A second boundary puts the slave's SDA release exactly on the last pulse of the last attempt (k = 81 against k = 82). There the pulse count, the presence of a STOP and the fail flag must all change together.

// File: rtl/i2cbc_pkg.sv
package i2cbc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_DISABLE,
    ST_ARM,
    ST_LOW,
    ST_RISE,
    ST_HIGH,
    ST_GAP,
    ST_STP_LOW,
    ST_STP_SDA,
    ST_STP_RISE,
    ST_STP_HOLD,
    ST_STP_FREE,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/bc_rst_sync.sv
module bc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/bc_sync.sv
module bc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q <= '1;
        end else begin
          stg_q[0] <= d_i;
          for (int s = 1; s < STAGES; s++) begin
            stg_q[s] <= stg_q[s-1];
          end
        end
      end

      assign q_o = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/bc_timer.sv
module bc_timer #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/bc_us_tick.sv
module bc_us_tick #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [PW-1:0] pre_i,
  output logic          tick_o
);

  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] last;

  assign last   = (pre_i == '0) ? '0 : pre_i - PW'(1);
  assign tick_o = en_i && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || tick_o) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = cnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/bc_seq.sv
module bc_seq
  import i2cbc_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int USD_W  = 16,
  parameter int PULSES = 9,
  parameter int TRIES  = 9,
  localparam int TW    = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic             tmr_zero_i,
  input  logic             tick_i,
  output logic             tmr_load_o,
  output logic [TW-1:0]    tmr_val_o,
  output logic             tick_clr_o,
  output logic             tick_en_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o
);

  localparam int PCW = $clog2(PULSES + 1);
  localparam int TCW = $clog2(TRIES + 1);
  localparam logic [PCW-1:0] PULSE_LAST = PCW'(PULSES);
  localparam logic [TCW-1:0] TRY_LAST   = TCW'(TRIES);

  seq_state_e       state_q, state_d;
  logic [PCW-1:0]   pulse_q, pulse_d, pulse_inc;
  logic [TCW-1:0]   try_q, try_d, try_inc;
  logic [USD_W-1:0] us_q, us_d;
  logic [USD_W-1:0] gap_q, gap_d, gap_calc;
  logic             fail_q, fail_d;
  logic             scl_oe_q, scl_oe_d;
  logic             sda_oe_q, sda_oe_d;
  logic [TW-1:0]    half_ext, dbl_ext;
  logic [USD_W+1:0] base_w, gap_w;

  assign half_ext  = {1'b0, half_div_i};
  assign dbl_ext   = {half_div_i, 1'b0};
  assign pulse_inc = pulse_q + PCW'(1);
  assign try_inc   = try_q + TCW'(1);

  // Inter-attempt gap in microseconds: twice max(2, period_us + 1), saturated.
  always_comb begin
    base_w = {2'b00, us_q} + (USD_W + 2)'(1);
    if (base_w < (USD_W + 2)'(2)) begin
      base_w = (USD_W + 2)'(2);
    end
    gap_w = base_w << 1;
    if (|gap_w[USD_W+1:USD_W]) begin
      gap_calc = '1;
    end else begin
      gap_calc = gap_w[USD_W-1:0];
    end
  end

  always_comb begin
    state_d    = state_q;
    pulse_d    = pulse_q;
    try_d      = try_q;
    us_d       = us_q;
    gap_d      = gap_q;
    fail_d     = fail_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = half_ext;
    tick_clr_o = 1'b0;
    tick_en_o  = (state_q == ST_CHECK) || (state_q == ST_GAP);

    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_CHECK;
          tmr_load_o = 1'b1;
          tmr_val_o  = dbl_ext;
          tick_clr_o = 1'b1;
          us_d       = '0;
          try_d      = '0;
          fail_d     = 1'b0;
        end
      end
      ST_CHECK: begin
        if (!tmr_zero_i) begin
          if (tick_i && !(&us_q)) begin
            us_d = us_q + USD_W'(1);
          end
        end else begin
          gap_d = gap_calc;
          if (sda_s_i && scl_s_i) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_DISABLE;
          end
        end
      end
      ST_DISABLE: begin
        state_d = ST_ARM;
        pulse_d = '0;
      end
      ST_ARM: begin
        state_d    = ST_LOW;
        tmr_load_o = 1'b1;
      end
      ST_LOW: begin
        if (tmr_zero_i && !scl_s_i) begin
          state_d = ST_RISE;
        end
      end
      ST_RISE: begin
        if (scl_s_i) begin
          state_d    = ST_HIGH;
          tmr_load_o = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tmr_zero_i) begin
          pulse_d = pulse_inc;
          if (sda_s_i) begin
            state_d    = ST_STP_LOW;
            tmr_load_o = 1'b1;
          end else if (pulse_inc == PULSE_LAST) begin
            try_d = try_inc;
            if (try_inc == TRY_LAST) begin
              fail_d  = 1'b1;
              state_d = ST_DONE;
            end else begin
              state_d    = ST_GAP;
              us_d       = gap_q;
              tick_clr_o = 1'b1;
            end
          end else begin
            state_d    = ST_LOW;
            tmr_load_o = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (us_q == '0) begin
          state_d = ST_DISABLE;
        end else if (tick_i) begin
          us_d = us_q - USD_W'(1);
        end
      end
      ST_STP_LOW: begin
        if (tmr_zero_i && !scl_s_i) begin
          state_d    = ST_STP_SDA;
          tmr_load_o = 1'b1;
        end
      end
      ST_STP_SDA: begin
        if (tmr_zero_i) begin
          state_d = ST_STP_RISE;
        end
      end
      ST_STP_RISE: begin
        if (scl_s_i) begin
          state_d    = ST_STP_HOLD;
          tmr_load_o = 1'b1;
        end
      end
      ST_STP_HOLD: begin
        if (tmr_zero_i) begin
          state_d    = ST_STP_FREE;
          tmr_load_o = 1'b1;
        end
      end
      ST_STP_FREE: begin
        if (tmr_zero_i) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  assign scl_oe_d = (state_d == ST_LOW) || (state_d == ST_STP_LOW) ||
                    (state_d == ST_STP_SDA);
  assign sda_oe_d = (state_d == ST_STP_SDA) || (state_d == ST_STP_RISE) ||
                    (state_d == ST_STP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pulse_q  <= '0;
      try_q    <= '0;
      us_q     <= '0;
      gap_q    <= '0;
      fail_q   <= 1'b0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      pulse_q  <= pulse_d;
      try_q    <= try_d;
      us_q     <= us_d;
      gap_q    <= gap_d;
      fail_q   <= fail_d;
      scl_oe_q <= scl_oe_d;
      sda_oe_q <= sda_oe_d;
    end
  end

  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign fail_o   = fail_q;

endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
  parameter int DIV_W       = 12,
  parameter int PRE_W       = 8,
  parameter int USD_W       = 16,
  parameter int PULSES      = 9,
  parameter int TRIES       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic [PRE_W-1:0] us_pre_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o
);

  localparam int TW = DIV_W + 1;

  logic          rst_sync_n;
  logic [1:0]    line_s;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          tick_clr, tick_en, tick;

  bc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  bc_timer #(.W(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  bc_us_tick #(.PW(PRE_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (tick_clr),
    .en_i   (tick_en),
    .pre_i  (us_pre_i),
    .tick_o (tick)
  );

  bc_seq #(
    .DIV_W  (DIV_W),
    .USD_W  (USD_W),
    .PULSES (PULSES),
    .TRIES  (TRIES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .half_div_i (half_div_i),
    .scl_s_i    (line_s[1]),
    .sda_s_i    (line_s[0]),
    .tmr_zero_i (tmr_zero),
    .tick_i     (tick),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .tick_clr_o (tick_clr),
    .tick_en_o  (tick_en),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
  );

endmodule

// File: rtl/bc_checker.sv
module bc_checker (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_o
);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R2
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R10
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  // R10
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(fail_o));

  // R4
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  // R11
  no_start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> scl_oe_o);

  // R7
  stop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_oe_o);

endmodule

bind i2c_bus_clear bc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start_i  (start_i),
  .scl_oe_o (scl_oe_o),
  .sda_oe_o (sda_oe_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .fail_o   (fail_o)
);

// File: tb/i2c_bus_clear_tb.sv
`timescale 1ns/1ps
module i2c_bus_clear_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] half_div = 12'd4;
  logic [7:0]  us_pre = 8'd3;
  logic        scl_oe, sda_oe, busy, done, fail;
  logic        scl_bus, sda_bus;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // task-owned slave configuration
  bit hold_en = 1'b0;
  int cur_k = 0, cur_h = 4, cur_pe = 3, cur_gapc = 0, cur_stl = 0;
  int fall_base = 0, rise_base = 0;

  // monitor-owned state
  int  rises = 0, falls = 0, stops = 0, starts = 0, dones = 0;
  int  hi_err = 0, lo_err = 0, gap_err = 0, gap_seen = 0;
  int  hi_len = 0, lo_len = 0, st_cnt = 0;
  bit  lo_valid = 1'b0;
  logic scl_prev = 1'b1, sda_prev = 1'b1;

  logic slv_sda_low, slv_scl_hold;
  assign slv_sda_low  = hold_en && ((falls - fall_base) < cur_k);
  assign slv_scl_hold = (st_cnt > 0);
  assign scl_bus = !(scl_oe || slv_scl_hold);
  assign sda_bus = !(sda_oe || slv_sda_low);

  always #2 clk = ~clk;

  i2c_bus_clear u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .half_div_i (half_div),
    .us_pre_i   (us_pre),
    .scl_i      (scl_bus),
    .sda_i      (sda_bus),
    .scl_oe_o   (scl_oe),
    .sda_oe_o   (sda_oe),
    .busy_o     (busy),
    .done_o     (done),
    .fail_o     (fail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bus monitor and slave model
  always @(negedge clk) begin
    logic s, d;
    int   idx;
    s = scl_bus;
    d = sda_bus;
    if (dones >= 0 && done) dones++;
    if (s && !scl_prev) begin
      rises++;
      if (lo_valid && lo_len < cur_h) lo_err++;
      hi_len = 1;
    end else if (s) begin
      hi_len++;
    end
    if (!s && scl_prev) begin
      idx = rises - rise_base;
      if (idx > 0) begin
        if ((idx % 9) == 0 && idx < 81 && idx < cur_k) begin
          gap_seen++;
          if (hi_len < cur_h + cur_gapc || hi_len > cur_h + cur_gapc + cur_pe + 24)
            gap_err++;
        end else if (hi_len < cur_h) begin
          hi_err++;
        end
      end
      lo_len   = 1;
      lo_valid = 1'b1;
    end else if (!s) begin
      lo_len++;
    end
    if (s && scl_prev && d && !sda_prev) stops++;
    if (s && scl_prev && !d && sda_prev) starts++;
    scl_prev = s;
    sda_prev = d;
    if (st_cnt > 0) st_cnt--;
    if (!s && scl_prev == 1'b0 && lo_len == 1 && cur_stl > 0) st_cnt = cur_stl;
    if (!s && lo_len == 1) falls++;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_case(input int k, input int h, input int p, input int stl,
                          input int extra_at, input bit coincide);
    int  pe, base, t, r0, s0, st0, he0, le0, ge0, gs0, d0, exp_rises, exp_stops, exp_gaps;
    bit  exp_fail, got_done, f_at_done;
    int  m;
    @(negedge clk);
    half_div = 12'(h);
    us_pre   = 8'(p);
    pe   = (p == 0) ? 1 : p;
    base = (2 * h) / pe + 1;
    if (base < 2) base = 2;
    cur_h    = h;
    cur_pe   = pe;
    cur_gapc = 2 * base * pe;
    cur_stl  = stl;
    cur_k    = k;
    fall_base = falls;
    hold_en  = (k > 0);
    repeat (4) @(negedge clk);
    rise_base = rises;
    r0 = rises; s0 = stops; st0 = starts; he0 = hi_err; le0 = lo_err;
    ge0 = gap_err; gs0 = gap_seen; d0 = dones;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(fail == 1'b0, "R10", "fail cleared by start", fail, 0);
    got_done = 1'b0;
    f_at_done = 1'b0;
    t = 0;
    while (!got_done && t < 60000) begin
      if (done) begin
        got_done  = 1'b1;
        f_at_done = fail;
      end else begin
        start = (t == extra_at);
        @(negedge clk);
        t++;
      end
    end
    start = 1'b0;
    chk(got_done, "R2", "done reached", got_done, 1);
    if (coincide) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b0, "R2", "start in done cycle ignored", busy, 0);
    end else begin
      @(negedge clk);
      chk(busy == 1'b0, "R2", "busy low after done", busy, 0);
    end
    chk(done == 1'b0, "R10", "done lasts one cycle", done, 0);
    repeat (30) @(negedge clk);
    if (coincide) chk(busy == 1'b0, "R2", "no restart from done-cycle strobe", busy, 0);
    if (k == 0) begin
      exp_fail = 1'b0; exp_rises = 0; exp_stops = 0;
    end else if (k <= 81) begin
      exp_fail = 1'b0; exp_rises = k + 1; exp_stops = 1;
    end else begin
      exp_fail = 1'b1; exp_rises = 81; exp_stops = 0;
    end
    m = (k - 1 < 80) ? k - 1 : 80;
    exp_gaps = (k == 0) ? 0 : m / 9;
    chk(f_at_done == exp_fail, (k == 0) ? "R3" : (exp_fail ? "R9" : "R7"),
        "fail at done", f_at_done, exp_fail);
    chk(fail == exp_fail, "R10", "fail held after done", fail, exp_fail);
    chk(rises - r0 == exp_rises, (k == 0) ? "R3" : (exp_fail ? "R9" : "R7"),
        "SCL rising edges", rises - r0, exp_rises);
    chk(stops - s0 == exp_stops, "R7", "STOP conditions", stops - s0, exp_stops);
    chk(starts - st0 == 0, "R11", "START conditions", starts - st0, 0);
    chk(hi_err - he0 == 0, "R5", "short SCL high phases", hi_err - he0, 0);
    chk(lo_err - le0 == 0, "R5", "short SCL low phases", lo_err - le0, 0);
    chk(gap_seen - gs0 == exp_gaps, "R6", "attempt boundaries", gap_seen - gs0, exp_gaps);
    chk(gap_err - ge0 == 0, "R8", "gap length out of bounds", gap_err - ge0, 0);
    chk(dones - d0 == 1, "R2", "done pulses", dones - d0, 1);
    chk(!scl_oe && !sda_oe, "R4", "lines released when idle", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1", "line enables in reset", {scl_oe, sda_oe}, 0);
    chk(!busy && !done && !fail, "R1", "status in reset", {busy, done, fail}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1", "line enables after reset", {scl_oe, sda_oe}, 0);
    chk(!busy && !done && !fail, "R1", "status after reset", {busy, done, fail}, 0);

    // R3 idle bus
    run_case(0, 4, 3, 0, -1, 1'b0);
    // R6 R7 sweep of release points, config A
    for (int k = 1; k <= 12; k++) run_case(k, 4, 3, 0, -1, 1'b0);
    run_case(18, 4, 3, 0, -1, 1'b0);
    run_case(80, 4, 3, 0, -1, 1'b0);
    run_case(81, 4, 3, 0, -1, 1'b0);
    // R9 exhaustion, then R10 fail cleared at next start
    run_case(82, 4, 3, 0, -1, 1'b0);
    run_case(95, 4, 3, 0, -1, 1'b0);
    run_case(5, 4, 3, 0, -1, 1'b0);
    // R5 clock stretching, config B
    for (int k = 1; k <= 6; k++) run_case(k, 6, 5, 11, -1, 1'b0);
    run_case(30, 6, 5, 11, -1, 1'b0);
    run_case(82, 6, 5, 11, -1, 1'b0);
    // R8 prescale of zero acts as one
    run_case(20, 4, 0, 0, -1, 1'b0);
    // R8 large prescale: base clamps to 2
    run_case(20, 3, 40, 0, -1, 1'b0);
    // R2 strobe mid-run ignored
    run_case(30, 4, 3, 0, 150, 1'b0);
    // R2 strobe in done cycle ignored
    run_case(7, 4, 3, 0, -1, 1'b1);
    run_case(0, 5, 2, 0, -1, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule